// File: doc/BRIEF.md
# Descriptor Ring Pointer Manager

This block keeps the producer and consumer indices of one circular descriptor ring in host memory. Software programs the ring's base address and entry count and posts work by moving the head index forward through a small register window. A processing engine on the hardware side sees a "descriptor available" signal together with the index of the oldest outstanding entry. It retires that entry with a one-cycle completion pulse, which moves the tail index forward.

The block computes the occupancy, the empty flag and the full flag from the two indices. It refuses any head update that would cross the tail and records each refusal in a sticky error bit that clears when software reads it. Reprogramming the base or size, or writing the reinitialise command, returns both indices to zero. Fetching the descriptors themselves is left to the engine.

Register window (byte offset, 32-bit access): 0x00 base low, 0x04 base high, 0x08 entry count, 0x0C head, 0x10 tail (read-only), 0x14 command (write-only, bit 0 = reinitialise), 0x1C status (bit 0 = refused head write, clear on read).

Top module: `ring_ptr_mgr`

## Requirements
- R1: After reset, head, tail and base read 0 and the entry count reads 2. The ring is empty, no descriptor is available and the status register reads 0.
- R2: A write to base low stores the data with bits [2:0] forced to zero. A write to base high stores the data as given. A write to either half sets head and tail to 0.
- R3: A write to the entry count with a power of two from 2 to 65536 updates the count and sets head and tail to 0. Any other value is ignored: the count, head and tail keep their values.
- R4: A command write with bit 0 set sets head and tail to 0 and leaves base and count unchanged. A command write with bit 0 clear changes nothing.
- R5: A head write is accepted only when the value is below the entry count and (value − tail) mod count ≥ (head − tail) mod count. Otherwise head is unchanged.
- R6: A refused head write sets status bit 0. A status read returns the flag and clears it after the read. When a refusal and a status read fall in the same cycle, the flag ends up set.
- R7: The pending count equals (head − tail) mod count. Empty is asserted exactly when head equals tail. Full is asserted exactly when pending equals count − 1.
- R8: The descriptor-available output equals "head differs from tail", and the descriptor index output equals tail. A completion pulse while a descriptor is available advances tail by one modulo the count. A completion pulse while the ring is empty is ignored.
- R9: Writes to the tail offset are ignored. The command offset and unmapped offsets read 0.
- R10: When a reinitialising write and a completion pulse fall in the same cycle, head and tail both end at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 5 | Register write byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe (needed for clear-on-read) |
| reg_raddr | input | 5 | Register read byte offset |
| reg_rdata | output | 32 | Register read data, combinational from reg_raddr |
| ring_base | output | 64 | Programmed ring base address |
| ring_empty | output | 1 | Head equals tail |
| ring_full | output | 1 | Pending equals count minus one |
| pending | output | 16 | Outstanding descriptors |
| desc_avail | output | 1 | A descriptor is ready for the engine |
| desc_idx | output | 16 | Index of the oldest outstanding descriptor (tail) |
| desc_done | input | 1 | One-cycle completion pulse from the engine |

## Verification
The hardest situation to reach is a full ring whose tail wraps past the top of the index space while software tries to post more work. A wide ring almost never fills from random head values. The random phase therefore mostly picks counts of 2 to 16, and it draws head offsets around the current head, including the offset that would land exactly on the tail. Directed cycles add the collisions that random stimulus rarely lines up: a refused head write in the same cycle as a status read, and a reinitialise command in the same cycle as a completion pulse.

// File: rtl/ring_pkg.sv
package ring_pkg;

  localparam logic [4:0] OFS_BASE_LO = 5'h00;
  localparam logic [4:0] OFS_BASE_HI = 5'h04;
  localparam logic [4:0] OFS_SIZE    = 5'h08;
  localparam logic [4:0] OFS_HEAD    = 5'h0C;
  localparam logic [4:0] OFS_TAIL    = 5'h10;
  localparam logic [4:0] OFS_CMD     = 5'h14;
  localparam logic [4:0] OFS_STATUS  = 5'h1C;

  // forward distance from b to a on a power-of-two ring
  function automatic logic [31:0] ring_dist(input logic [31:0] a,
                                            input logic [31:0] b,
                                            input logic [31:0] mask);
    return (a - b) & mask;
  endfunction

  // legal entry count: power of two within [2, 2**max_log2]
  function automatic logic size_ok(input logic [31:0] v,
                                   input int unsigned max_log2);
    logic pow2;
    pow2 = (v != 32'd0) && ((v & (v - 32'd1)) == 32'd0);
    return pow2 && (v >= 32'd2) && (v <= (32'd1 << max_log2));
  endfunction

endpackage

// File: rtl/ring_size_reg.sv
module ring_size_reg #(
  parameter int unsigned MAX_LOG2 = 16,
  localparam int unsigned IDX_W   = MAX_LOG2,
  localparam int unsigned SZ_W    = MAX_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [31:0]       wdata,
  output logic [SZ_W-1:0]   size,
  output logic [IDX_W-1:0]  size_mask,
  output logic              taken
);
  import ring_pkg::*;

  assign taken = wr && size_ok(wdata, MAX_LOG2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     size <= SZ_W'(2);
    else if (taken) size <= SZ_W'(wdata);
  end

  assign size_mask = IDX_W'(size - SZ_W'(1));
endmodule

// File: rtl/ring_head_ctrl.sv
module ring_head_ctrl #(
  parameter int unsigned IDX_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reinit,
  input  logic              wr,
  input  logic [31:0]       wdata,
  input  logic [IDX_W-1:0]  tail,
  input  logic [IDX_W-1:0]  size_mask,
  input  logic              stat_rd,
  output logic [IDX_W-1:0]  head,
  output logic              accept,
  output logic              reject,
  output logic              err
);
  import ring_pkg::*;

  logic        in_range;
  logic [31:0] dist_new;
  logic [31:0] dist_old;

  assign in_range = (wdata <= 32'(size_mask));
  assign dist_new = ring_dist(wdata, 32'(tail), 32'(size_mask));
  assign dist_old = ring_dist(32'(head), 32'(tail), 32'(size_mask));
  assign accept   = wr && in_range && (dist_new >= dist_old);
  assign reject   = wr && !accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      head <= '0;
    else if (reinit) head <= '0;
    else if (accept) head <= IDX_W'(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err <= 1'b0;
    else if (reject)  err <= 1'b1;
    else if (stat_rd) err <= 1'b0;
  end
endmodule

// File: rtl/ring_tail_ctrl.sv
module ring_tail_ctrl #(
  parameter int unsigned IDX_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reinit,
  input  logic              done,
  input  logic [IDX_W-1:0]  head,
  input  logic [IDX_W-1:0]  size_mask,
  output logic [IDX_W-1:0]  tail,
  output logic              adv
);
  assign adv = done && (tail != head);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tail <= '0;
    else if (reinit) tail <= '0;
    else if (adv)    tail <= (tail + IDX_W'(1)) & size_mask;
  end
endmodule

// File: rtl/ring_ptr_mgr.sv
module ring_ptr_mgr #(
  parameter int unsigned MAX_LOG2 = 16,
  parameter int unsigned ADDR_W   = 64,
  localparam int unsigned IDX_W   = MAX_LOG2,
  localparam int unsigned SZ_W    = MAX_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [4:0]        reg_waddr,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_rd,
  input  logic [4:0]        reg_raddr,
  output logic [31:0]       reg_rdata,
  output logic [ADDR_W-1:0] ring_base,
  output logic              ring_empty,
  output logic              ring_full,
  output logic [IDX_W-1:0]  pending,
  output logic              desc_avail,
  output logic [IDX_W-1:0]  desc_idx,
  input  logic              desc_done
);
  import ring_pkg::*;

  // named internal events
  logic              wr_base_lo, wr_base_hi, wr_size, wr_head, wr_cmd;
  logic              size_taken, reinit, head_accept, head_reject, tail_adv;
  logic              stat_rd, err;
  logic [SZ_W-1:0]   size;
  logic [IDX_W-1:0]  size_mask, head, tail;
  logic [ADDR_W-1:0] base_q;

  assign wr_base_lo = reg_wr && (reg_waddr == OFS_BASE_LO);
  assign wr_base_hi = reg_wr && (reg_waddr == OFS_BASE_HI);
  assign wr_size    = reg_wr && (reg_waddr == OFS_SIZE);
  assign wr_head    = reg_wr && (reg_waddr == OFS_HEAD);
  assign wr_cmd     = reg_wr && (reg_waddr == OFS_CMD);
  assign stat_rd    = reg_rd && (reg_raddr == OFS_STATUS);

  assign reinit = wr_base_lo || wr_base_hi || size_taken ||
                  (wr_cmd && reg_wdata[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          base_q <= '0;
    else if (wr_base_lo) base_q[31:0] <= {reg_wdata[31:3], 3'b000};
    else if (wr_base_hi) base_q[ADDR_W-1:32] <= (ADDR_W-32)'(reg_wdata);
  end

  ring_size_reg #(.MAX_LOG2(MAX_LOG2)) u_size (
    .clk(clk), .rst_n(rst_n), .wr(wr_size), .wdata(reg_wdata),
    .size(size), .size_mask(size_mask), .taken(size_taken)
  );

  ring_head_ctrl #(.IDX_W(IDX_W)) u_head (
    .clk(clk), .rst_n(rst_n), .reinit(reinit), .wr(wr_head),
    .wdata(reg_wdata), .tail(tail), .size_mask(size_mask),
    .stat_rd(stat_rd), .head(head), .accept(head_accept),
    .reject(head_reject), .err(err)
  );

  ring_tail_ctrl #(.IDX_W(IDX_W)) u_tail (
    .clk(clk), .rst_n(rst_n), .reinit(reinit), .done(desc_done),
    .head(head), .size_mask(size_mask), .tail(tail), .adv(tail_adv)
  );

  assign pending    = IDX_W'(ring_dist(32'(head), 32'(tail), 32'(size_mask)));
  assign ring_empty = (head == tail);
  assign ring_full  = (pending == size_mask);
  assign desc_avail = !ring_empty;
  assign desc_idx   = tail;
  assign ring_base  = base_q;

  always_comb begin
    unique case (reg_raddr)
      OFS_BASE_LO: reg_rdata = base_q[31:0];
      OFS_BASE_HI: reg_rdata = 32'(base_q[ADDR_W-1:32]);
      OFS_SIZE:    reg_rdata = 32'(size);
      OFS_HEAD:    reg_rdata = 32'(head);
      OFS_TAIL:    reg_rdata = 32'(tail);
      OFS_STATUS:  reg_rdata = {31'd0, err};
      default:     reg_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/ring_ptr_chk.sv
module ring_ptr_chk #(
  parameter int unsigned IDX_W = 16,
  parameter int unsigned SZ_W  = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reinit,
  input logic             head_reject,
  input logic             desc_done,
  input logic             desc_avail,
  input logic             ring_empty,
  input logic             err,
  input logic [IDX_W-1:0] pending,
  input logic [IDX_W-1:0] head,
  input logic [IDX_W-1:0] tail,
  input logic [SZ_W-1:0]  size,
  input logic [IDX_W-1:0] size_mask
);
  assert_empty_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ring_empty == (pending == '0));

  assert_avail_R8: assert property (@(posedge clk) disable iff (!rst_n)
    desc_avail == (head != tail));

  assert_tail_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_done && desc_avail && !reinit) |=>
      tail == (($past(tail) + IDX_W'(1)) & $past(size_mask)));

  assert_tail_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!desc_done && !reinit) |=> $stable(tail));

  assert_reinit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reinit |=> (head == '0) && (tail == '0));

  assert_head_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (head <= size_mask) && (tail <= size_mask));

  assert_reject_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    head_reject |=> $stable(head));

  assert_err_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    head_reject |=> err);

  assert_size_pow2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(size) == 1) && (size >= SZ_W'(2)));
endmodule

bind ring_ptr_mgr ring_ptr_chk #(.IDX_W(IDX_W), .SZ_W(SZ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reinit(reinit), .head_reject(head_reject),
  .desc_done(desc_done), .desc_avail(desc_avail), .ring_empty(ring_empty),
  .err(err), .pending(pending), .head(head), .tail(tail), .size(size),
  .size_mask(size_mask)
);

// File: tb/sim_ring_ptr_mgr.sv
`timescale 1ns/1ps
module sim_ring_ptr_mgr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, desc_done = 1'b0;
  logic [4:0]  reg_waddr = '0, reg_raddr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [63:0] ring_base;
  logic        ring_empty, ring_full, desc_avail;
  logic [15:0] pending, desc_idx;

  int n_run = 0, n_fail = 0;
  bit done_flag = 0;

  // bench model
  logic [31:0] m_head = 0, m_tail = 0, m_size = 2;
  logic [63:0] m_base = 0;
  logic        m_err = 0;
  logic [31:0] last_rd;

  always #2 clk = ~clk;

  ring_ptr_mgr u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_raddr(reg_raddr),
    .reg_rdata(reg_rdata), .ring_base(ring_base), .ring_empty(ring_empty),
    .ring_full(ring_full), .pending(pending), .desc_avail(desc_avail),
    .desc_idx(desc_idx), .desc_done(desc_done)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_pend();
    return (m_head + m_size - m_tail) % m_size;
  endfunction

  function automatic bit legal_size(input logic [31:0] v);
    for (int k = 1; k <= 16; k++) if (v == (32'd1 << k)) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] m_read(input logic [4:0] a);
    case (a)
      5'h00: return m_base[31:0];
      5'h04: return m_base[63:32];
      5'h08: return m_size;
      5'h0C: return m_head;
      5'h10: return m_tail;
      5'h1C: return {31'd0, m_err};
      default: return 32'd0;
    endcase
  endfunction

  // one clock of stimulus; model follows the requirements
  task automatic tick(input bit w, input logic [4:0] wa, input logic [31:0] wd,
                      input bit d, input bit r, input logic [4:0] ra);
    bit re, acc, rej;
    @(negedge clk);
    reg_wr = w; reg_waddr = wa; reg_wdata = wd; desc_done = d;
    reg_rd = r; reg_raddr = ra;
    #1 last_rd = reg_rdata;
    chk("R9 read data", last_rd, m_read(ra));
    @(posedge clk);
    #0.5;
    reg_wr = 0; desc_done = 0; reg_rd = 0;
    re = 0; acc = 0; rej = 0;
    if (w) begin
      case (wa)
        5'h00: begin m_base[31:0] = wd & 32'hFFFF_FFF8; re = 1; end
        5'h04: begin m_base[63:32] = wd; re = 1; end
        5'h08: if (legal_size(wd)) begin m_size = wd; re = 1; end
        5'h0C: begin
          acc = (wd < m_size) &&
                (((wd + m_size - m_tail) % m_size) >= m_pend());
          rej = !acc;
        end
        5'h14: if (wd[0]) re = 1;
        default: ;
      endcase
    end
    if (d && (m_head != m_tail)) m_tail = (m_tail + 1) % m_size;
    if (acc) m_head = wd;
    if (rej) m_err = 1;
    else if (r && ra == 5'h1C) m_err = 0;
    if (re) begin m_head = 0; m_tail = 0; end
  endtask

  task automatic chk_out(input string tag);
    @(negedge clk); #1;
    chk({tag, " empty R7"}, ring_empty, m_head == m_tail);
    chk({tag, " full R7"}, ring_full, m_pend() == m_size - 1);
    chk({tag, " pending R7"}, pending, m_pend());
    chk({tag, " avail R8"}, desc_avail, m_head != m_tail);
    chk({tag, " idx R8"}, desc_idx, m_tail);
    chk({tag, " base R2"}, ring_base, m_base);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    tick(1, a, d, 0, 0, 5'h0);
  endtask

  task automatic rd(input logic [4:0] a, input string tag, input logic [31:0] exp);
    tick(0, 5'h0, 0, 0, 1, a);
    chk(tag, last_rd, exp);
  endtask

  initial begin
    #(4 * 150000);
    if (!done_flag) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    v = $urandom(32'd1234);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    chk_out("R1 reset");
    rd(5'h08, "R1 size", 2);
    rd(5'h0C, "R1 head", 0);
    rd(5'h10, "R1 tail", 0);
    rd(5'h1C, "R1 status", 0);

    // R2 base alignment and pointer reset
    wr(5'h08, 8); wr(5'h0C, 5);
    chk_out("R5 head 5");
    wr(5'h00, 32'h1234_5677);
    rd(5'h00, "R2 base lo aligned", 32'h1234_5670);
    rd(5'h0C, "R2 head reset", 0);
    wr(5'h0C, 3); wr(5'h04, 32'hCAFE_0001);
    rd(5'h04, "R2 base hi", 32'hCAFE_0001);
    chk_out("R2 after hi");

    // R3 size legality
    wr(5'h0C, 3);
    wr(5'h08, 6);
    rd(5'h08, "R3 size 6 ignored", 8);
    rd(5'h0C, "R3 head kept", 3);
    wr(5'h08, 1);  rd(5'h08, "R3 size 1 ignored", 8);
    wr(5'h08, 0);  rd(5'h08, "R3 size 0 ignored", 8);
    wr(5'h08, 32'h20000); rd(5'h08, "R3 size 131072 ignored", 8);
    wr(5'h08, 32'h10000); rd(5'h08, "R3 size 65536", 32'h10000);
    rd(5'h0C, "R3 head reset", 0);

    // R4 command
    wr(5'h08, 16); wr(5'h0C, 9);
    wr(5'h14, 0); rd(5'h0C, "R4 cmd bit0 clear", 9);
    wr(5'h14, 1); chk_out("R4 reinit");
    rd(5'h08, "R4 size kept", 16);

    // R5/R6/R7 full ring and refusal
    wr(5'h08, 4); wr(5'h0C, 3);
    chk_out("R7 full");
    wr(5'h0C, 0); rd(5'h0C, "R5 refuse wrap", 3);
    wr(5'h0C, 4); rd(5'h0C, "R5 refuse out of range", 3);
    rd(5'h1C, "R6 err set", 1);
    rd(5'h1C, "R6 err cleared", 0);

    // R8 completions and tail wrap
    repeat (3) tick(0, 0, 0, 1, 0, 0);
    chk_out("R8 drained");
    tick(0, 0, 0, 1, 0, 0);
    rd(5'h10, "R8 done on empty ignored", 3);
    wr(5'h0C, 2);
    tick(0, 0, 0, 1, 0, 0);
    rd(5'h10, "R8 tail wrap", 0);
    chk_out("R8 wrap");

    // R6 set wins over clear-on-read
    wr(5'h0C, 3);
    tick(1, 5'h0C, 1, 0, 1, 5'h1C);
    rd(5'h1C, "R6 set wins", 1);
    rd(5'h1C, "R6 cleared", 0);

    // R10 reinit vs completion
    tick(1, 5'h14, 1, 1, 0, 0);
    chk_out("R10 reinit+done");

    // R9 map
    wr(5'h0C, 2);
    wr(5'h10, 1); rd(5'h10, "R9 tail write ignored", 0);
    rd(5'h14, "R9 cmd reads 0", 0);
    rd(5'h18, "R9 unmapped reads 0", 0);

    // constrained random
    for (int i = 0; i < 600; i++) begin
      logic [31:0] sel, val;
      sel = $urandom % 100;
      if (sel < 4) begin
        case ($urandom % 4)
          0: val = 2; 1: val = 4; 2: val = 8; default: val = 16;
        endcase
        if ($urandom % 4 == 0) val = val + 1;
        tick(1, 5'h08, val, $urandom % 2, 0, 0);
      end else if (sel < 6) begin
        tick(1, 5'h14, $urandom % 2, $urandom % 2, 0, 0);
      end else if (sel < 50) begin
        val = (m_head + ($urandom % (m_size + 1))) % m_size;
        if ($urandom % 10 == 0) val = m_size + ($urandom % 4);
        tick(1, 5'h0C, val, $urandom % 2, $urandom % 3 == 0, 5'h1C);
      end else begin
        tick(0, 0, 0, 1, $urandom % 2, 5'(($urandom % 8) * 4));
      end
      if (i % 5 == 0) chk_out("random R5 R7 R8");
    end

    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule